// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog built around a down-counter that runs off a divided watchdog clock. A 32-bit option word fixes its whole configuration at reset:
- whether it starts counting on its own or stays halted,
- the timeout length,
- the clock division ratio,
- a refresh window, bounded by a start and an end point given as fractions of the timeout,
- whether a fault raises a reset request or a non-maskable interrupt request,
- whether counting pauses while the system sits in a low-power mode.

Software keeps the timer alive with a two-write refresh sequence: a zero byte, then an all-ones byte. The second write is judged against the window. Inside the window it reloads the counter. Outside the window it is a refresh error. An underflow or a refresh error latches a status flag and raises the selected request. Both the flag and the request stay set until the next reset.

Top module: `gtm_watchdog`

## Requirements
- R1: While `rst_n` is low the option word is captured. After reset, `count` equals the initial value selected by the timeout field, and both flags and both requests read 0. Option bits 0, 13 and 31:15 are expected to be 1.
- R2: Option bits 3:2 select the initial value as follows. The counter then never exceeds that value.

  | Bits 3:2 | Initial value | Timeout (ticks) |
  |---|---|---|
  | 00 | 127 | 128 |
  | 01 | 511 | 512 |
  | 10 | 1023 | 1024 |
  | 11 | 2047 | 2048 |

- R3: Option bits 7:4 set the clock division ratio N. The counter decrements once every N clock cycles.

  | Bits 7:4 | N |
  |---|---|
  | 0000 | 1 |
  | 0010 | 16 |
  | 0011 | 32 |
  | 0100 | 64 |
  | 1111 | 128 |
  | 0101 | 256 |
  | any other code | 256 |

- R4: Option bit 1 chooses the start mode. With bit 1 = 0 the counter runs from reset. With bit 1 = 1 it holds its value until a `start_req` pulse or a valid refresh sequence, and the first decrement comes N cycles after that. `start_req` has no effect once the counter is running.
- R5: When the counter is at 0 and a tick arrives, the counter reloads to the initial value and `uflow_flag` sets.
- R6: Option bit 12 selects the fault response. With bit 12 = 1 a fault sets `rst_req`; with bit 12 = 0 it sets `nmi_req`. The other request stays 0.
- R7: A refresh attempt is a `kick_wr` of data FFh whose previous `kick_wr` carried 00h. A write of any other value breaks the sequence. A lone FFh is ignored: it causes no reload and no error.
- R8: Let P be the timeout and Q = P/4. The start quarter S is (bits 11:10) + 1, meaning 00→1 and 11→4. The end quarter E is 3 − (bits 9:8), meaning 00→3 and 11→0. A refresh attempt while running is valid when E·Q ≤ count < S·Q. A valid attempt reloads the counter to the initial value on the next cycle.
- R9: A refresh attempt while running that falls outside the window sets `kerr_flag` and raises the selected request. It does not reload the counter.
- R10: When option bit 14 = 1 and `low_power` is high, the counter and the prescaler hold. When bit 14 = 0, `low_power` has no effect.
- R11: In halted mode a refresh attempt starts the counter without any window check and without setting an error.
- R12: `uflow_flag`, `kerr_flag`, `rst_req` and `nmi_req` remain set until reset, even across later refreshes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Synchronous active-low reset; the option word is sampled while it is low |
| opt_word | input | 32 | Option word (configuration) |
| kick_wr | input | 1 | Refresh register write strobe |
| kick_data | input | KICK_W | Refresh register write data |
| start_req | input | 1 | Start strobe for halted mode |
| low_power | input | 1 | Low-power (sleep or standby) indication |
| rst_req | output | 1 | Sticky reset request |
| nmi_req | output | 1 | Sticky non-maskable interrupt request |
| count | output | CNT_W | Current down-counter value |
| uflow_flag | output | 1 | Sticky underflow flag |
| kerr_flag | output | 1 | Sticky refresh-error flag |

## Verification
Every result is registered, so each one is due in the cycle after the edge that decides it. With no division, the first decrement follows the first edge after reset or start. With ratio N, the count first drops on the Nth edge. Underflow, its reload, the flag and the request all appear together after P edges from reset. A refresh is judged on the edge that takes the FFh byte, using the count shown just before that edge. The outcome appears right after that edge: the count reloads if the refresh was valid, or it decrements and the error flag sets if it was not. The bench drives and samples on falling edges, counts rising edges exactly, and compares against values computed from the option fields. It sweeps all division codes, all timeouts and all sixteen window settings, at count values on both sides of each quarter boundary.

// File: rtl/gtm_pkg.sv
package gtm_pkg;

  // Initial counter value for a timeout field code
  function automatic int top_of(input logic [1:0] code);
    case (code)
      2'd0:    return 127;
      2'd1:    return 511;
      2'd2:    return 1023;
      default: return 2047;
    endcase
  endfunction

  // Division ratio; codes without a defined ratio fall back to 256
  function automatic int div_of(input logic [3:0] code);
    case (code)
      4'h0:    return 1;
      4'h2:    return 16;
      4'h3:    return 32;
      4'h4:    return 64;
      4'hF:    return 128;
      default: return 256;
    endcase
  endfunction

  // Window test in quarters of the period still remaining on the counter
  function automatic logic win_ok(input int cnt, input int top,
                                  input logic [1:0] start_code,
                                  input logic [1:0] end_code);
    int q;
    int lo;
    int hi;
    q  = (top + 1) / 4;
    lo = (3 - int'(end_code)) * q;
    hi = (int'(start_code) + 1) * q;
    return (cnt >= lo) && (cnt < hi);
  endfunction

endpackage

// File: rtl/gtm_prescaler.sv
module gtm_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           clear,
  input  logic [PRE_W:0] ratio,
  output logic           tick
);
  localparam int RATIO_W = PRE_W + 1;

  logic [PRE_W-1:0] pre;
  logic             last;

  assign last = ({1'b0, pre} == ratio - RATIO_W'(1));
  assign tick = run && last;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) pre <= '0;
    else if (run)        pre <= last ? '0 : pre + PRE_W'(1);
  end

  assert_pre_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, pre} < ratio);

endmodule

// File: rtl/gtm_kick_seq.sv
module gtm_kick_seq #(
  parameter int KICK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [KICK_W-1:0] data,
  output logic              attempt
);
  logic armed;

  assign attempt = wr && (data == '1) && armed;

  always_ff @(posedge clk) begin
    if (!rst_n)  armed <= 1'b0;
    else if (wr) armed <= (data == '0);
  end

  assert_attempt_follows_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    attempt |-> $past(wr && data == '0));

endmodule

// File: rtl/gtm_window.sv
module gtm_window import gtm_pkg::*; #(
  parameter int CNT_W = 11
) (
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] top,
  input  logic [1:0]       start_code,
  input  logic [1:0]       end_code,
  output logic             ok
);
  assign ok = win_ok(int'(count), int'(top), start_code, end_code);
endmodule

// File: rtl/gtm_watchdog.sv
module gtm_watchdog import gtm_pkg::*; #(
  parameter int CNT_W  = 11,
  parameter int PRE_W  = 8,
  parameter int KICK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       opt_word,
  input  logic              kick_wr,
  input  logic [KICK_W-1:0] kick_data,
  input  logic              start_req,
  input  logic              low_power,
  output logic              rst_req,
  output logic              nmi_req,
  output logic [CNT_W-1:0]  count,
  output logic              uflow_flag,
  output logic              kerr_flag
);
  localparam int RATIO_W = PRE_W + 1;

  logic [31:0]        cfg_q;
  logic               running;
  logic [CNT_W-1:0]   top_val;
  logic [RATIO_W-1:0] ratio;
  logic               cfg_rsvd;
  logic               frozen;
  logic               advance;
  logic               tick;
  logic               attempt;
  logic               in_win;
  logic               start_evt;
  logic               good_kick;
  logic               bad_kick;
  logic               underflow;
  logic               reload_cnt;
  logic               fault;

  assign top_val  = CNT_W'(top_of(cfg_q[3:2]));
  assign ratio    = RATIO_W'(div_of(cfg_q[7:4]));
  assign cfg_rsvd = &{cfg_q[31:15], cfg_q[13], cfg_q[0]};
  assign frozen   = cfg_q[14] && low_power;
  assign advance  = running && !frozen;

  gtm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(advance),
    .clear(start_evt || good_kick), .ratio(ratio), .tick(tick)
  );

  gtm_kick_seq #(.KICK_W(KICK_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr(kick_wr), .data(kick_data), .attempt(attempt)
  );

  gtm_window #(.CNT_W(CNT_W)) u_win (
    .count(count), .top(top_val), .start_code(cfg_q[11:10]),
    .end_code(cfg_q[9:8]), .ok(in_win)
  );

  assign start_evt  = !running && (start_req || attempt);
  assign good_kick  = running && attempt && in_win;
  assign bad_kick   = running && attempt && !in_win;
  assign underflow  = tick && (count == '0) && !good_kick;
  assign reload_cnt = start_evt || good_kick || underflow;
  assign fault      = underflow || bad_kick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q      <= opt_word;
      running    <= !opt_word[1];
      count      <= CNT_W'(top_of(opt_word[3:2]));
      uflow_flag <= 1'b0;
      kerr_flag  <= 1'b0;
      rst_req    <= 1'b0;
      nmi_req    <= 1'b0;
    end else begin
      if (start_evt)       running <= 1'b1;
      if (reload_cnt)      count   <= top_val;
      else if (tick)       count   <= count - CNT_W'(1);
      if (underflow)       uflow_flag <= 1'b1;
      if (bad_kick)        kerr_flag  <= 1'b1;
      if (fault) begin
        if (cfg_q[12])     rst_req <= 1'b1;
        else               nmi_req <= 1'b1;
      end
    end
  end

  assert_reserved_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rsvd);
  assert_count_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= top_val);
  assert_halted_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start_req && !attempt) |=> $stable(count));
  assert_reload_on_uflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> (count == top_val) && uflow_flag);
  assert_single_response_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && nmi_req));
  assert_valid_refresh_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    good_kick |=> count == top_val);
  assert_bad_refresh_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_kick |=> kerr_flag && (rst_req || nmi_req));
  assert_lowpower_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (running && frozen && !attempt) |=> $stable(count));
  assert_uflow_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    uflow_flag |=> uflow_flag);
  assert_kerr_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    kerr_flag |=> kerr_flag);

endmodule

// File: tb/tb_gtm_watchdog.sv
`timescale 1ns/1ps
module tb_gtm_watchdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opt_word = 32'hFFFF_FFFF;
  logic        kick_wr = 1'b0;
  logic [7:0]  kick_data = 8'h00;
  logic        start_req = 1'b0;
  logic        low_power = 1'b0;
  logic        rst_req, nmi_req, uflow_flag, kerr_flag;
  logic [10:0] count;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  gtm_watchdog dut (
    .clk(clk), .rst_n(rst_n), .opt_word(opt_word), .kick_wr(kick_wr),
    .kick_data(kick_data), .start_req(start_req), .low_power(low_power),
    .rst_req(rst_req), .nmi_req(nmi_req), .count(count),
    .uflow_flag(uflow_flag), .kerr_flag(kerr_flag)
  );

  function automatic logic [31:0] mk(input bit halt, input int tops, input int cks,
                                     input int endc, input int startc, input bit rsel,
                                     input bit slp);
    logic [31:0] w;
    w = 32'hFFFF_A001;
    w[1] = halt;
    w[3:2] = 2'(tops);
    w[7:4] = 4'(cks);
    w[9:8] = 2'(endc);
    w[11:10] = 2'(startc);
    w[12] = rsel;
    w[14] = slp;
    return w;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [31:0] w);
    @(negedge clk);
    rst_n = 1'b0; opt_word = w; kick_wr = 1'b0; start_req = 1'b0; low_power = 1'b0;
    step(3);
    rst_n = 1'b1;
  endtask

  task automatic kick(input logic [7:0] d);
    kick_wr = 1'b1; kick_data = d;
    step(1);
    kick_wr = 1'b0;
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R1/R2: reset state per timeout code; R5/R6: underflow timing and response
    for (int t = 0; t < 4; t++) begin
      int top;
      top = (t == 0) ? 127 : (t == 1) ? 511 : (t == 2) ? 1023 : 2047;
      do_reset(mk(0, t, 0, 3, 3, t[0], 0));
      check("R1 count after reset", int'(count), top);
      check("R1 flags after reset", int'({uflow_flag, kerr_flag, rst_req, nmi_req}), 0);
      step(top);
      check("R5 count at zero", int'(count), 0);
      check("R5 no flag before underflow", int'(uflow_flag), 0);
      step(1);
      check("R2 reload after full period", int'(count), top);
      check("R5 underflow flag", int'(uflow_flag), 1);
      check("R6 reset request", int'(rst_req), t % 2);
      check("R6 nmi request", int'(nmi_req), 1 - (t % 2));
    end

    // R3: every division code
    for (int c = 0; c < 16; c++) begin
      int n;
      n = (c == 0) ? 1 : (c == 2) ? 16 : (c == 3) ? 32 : (c == 4) ? 64 : (c == 15) ? 128 : 256;
      do_reset(mk(0, 0, c, 3, 3, 0, 0));
      step(n - 1);
      check("R3 held before tick", int'(count), 127);
      step(1);
      check("R3 first decrement", int'(count), 126);
    end

    // R4: halted mode and start strobe
    do_reset(mk(1, 0, 0, 3, 3, 0, 0));
    step(40);
    check("R4 halted holds", int'(count), 127);
    start_req = 1'b1; step(1); start_req = 1'b0;
    check("R4 count at start", int'(count), 127);
    step(1);
    check("R4 counting after start", int'(count), 126);
    start_req = 1'b1; step(1); start_req = 1'b0;
    check("R4 start ignored while running", int'(count), 125);

    // R11: halted mode started by a refresh sequence (window would be empty)
    do_reset(mk(1, 0, 0, 0, 0, 0, 0));
    step(10);
    kick(8'h00); kick(8'hFF);
    check("R11 count at start", int'(count), 127);
    check("R11 no error", int'(kerr_flag), 0);
    step(1);
    check("R11 counting", int'(count), 126);

    // R8/R9/R6: full window sweep around quarter boundaries
    for (int s = 0; s < 4; s++) begin
      for (int e = 0; e < 4; e++) begin
        int cs[8];
        cs = '{1, 31, 32, 63, 64, 95, 96, 126};
        for (int k = 0; k < 8; k++) begin
          int c;
          bit valid;
          bit rsel;
          c = cs[k];
          rsel = bit'((s + e) % 2);
          valid = (c >= (3 - e) * 32) && (c < (s + 1) * 32);
          do_reset(mk(0, 0, 0, e, s, rsel, 0));
          step(126 - c);
          kick(8'h00); kick(8'hFF);
          check("R8 count after refresh", int'(count), valid ? 127 : c - 1);
          check("R9 refresh error flag", int'(kerr_flag), valid ? 0 : 1);
          check("R6 reset on refresh error", int'(rst_req), (!valid && rsel) ? 1 : 0);
          check("R6 nmi on refresh error", int'(nmi_req), (!valid && !rsel) ? 1 : 0);
        end
      end
    end

    // R7: broken sequence and lone FFh are ignored
    do_reset(mk(0, 0, 0, 3, 3, 0, 0));
    step(10);
    kick(8'h00); kick(8'h55); kick(8'hFF);
    check("R7 broken sequence no reload", int'(count), 114);
    kick(8'h00); kick(8'hFF);
    check("R7 proper sequence reloads", int'(count), 127);
    do_reset(mk(0, 0, 0, 0, 0, 0, 0));
    step(5);
    kick(8'hFF);
    check("R7 lone FF no reload", int'(count), 121);
    check("R7 lone FF no error", int'(kerr_flag), 0);
    kick(8'h00); kick(8'hFF);
    check("R9 empty window errors", int'(kerr_flag), 1);
    check("R9 no reload on error", int'(count), 119);

    // R10: low-power stop
    do_reset(mk(0, 0, 0, 3, 3, 0, 1));
    step(5);
    low_power = 1'b1; step(20); low_power = 1'b0;
    check("R10 held in low power", int'(count), 122);
    step(3);
    check("R10 resumes", int'(count), 119);
    do_reset(mk(0, 0, 0, 3, 3, 0, 0));
    step(5);
    low_power = 1'b1; step(20); low_power = 1'b0;
    check("R10 ignored when disabled", int'(count), 102);

    // R12: stickiness
    do_reset(mk(0, 0, 0, 3, 3, 1, 0));
    step(128);
    check("R12 underflow seen", int'(uflow_flag), 1);
    kick(8'h00); kick(8'hFF);
    step(10);
    check("R12 underflow flag sticky", int'(uflow_flag), 1);
    check("R12 reset request sticky", int'(rst_req), 1);
    check("R12 refresh still works", int'(count), 117);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule